// File: doc/BRIEF.md
# DMA Bridge Interrupt Flag Unit

This block collects completion and error events for a DMA bridge that moves data for four audio directions (receive and transmit for audio channels 0 and 1) and for one USB path. For every audio direction it keeps a byte counter against a programmed total. It detects the transfer midpoint and the transfer end in each direction. It also takes two single-cycle USB events: transfer done and address error. The data movement, bus arbitration and address checking sit outside this block. They reach it only as event pulses and byte increments.

Each event has an enable bit. An enabled event sets a sticky flag, and the flags are gathered onto three interrupt lines by event class: address error, end of transfer and midpoint of transfer. Software reads the flags and enables through a small register port. It writes enables and transfer totals there, and clears flags by writing 0 to them. An interrupt handler reads the flag word to find the cause, then clears the bits it has handled.

Top module: `dma_irq_flags`

## Requirements
- R1: `irq_err_o` is 1 exactly when flag bit 0 is 1. `irq_end_o` is the OR of flag bits 1 to 5. `irq_half_o` is the OR of flag bits 6 to 9. Each line stays 1 until every flag in its group is 0.
- R2: Register map by `reg_addr_i`: 0 holds the 10-bit enable word (read/write). 1 holds the 10-bit flag word (read; a written 0 clears that flag, a written 1 leaves it unchanged). 2+d holds the 12-bit byte total of direction d (read/write). Every other address and every unused bit reads 0. Flag and enable bit positions: 0 is USB address error, 1 is USB done, 2+d is end of direction d, 6+d is midpoint of direction d. Direction d is 0 for ch0 rx, 1 for ch0 tx, 2 for ch1 rx and 3 for ch1 tx.
- R3: A pulse on `usb_addr_err_i` sets flag bit 0 at that clock edge when enable bit 0 is 1.
- R4: A pulse on `usb_end_i` sets flag bit 1 at that clock edge when enable bit 1 is 1.
- R5: In an armed transfer, the midpoint event of direction d fires once, in the first increment cycle in which the new count is >= floor(total/2). It sets flag 6+d if that flag is enabled.
- R6: In an armed transfer, the end event of direction d fires in the increment cycle in which the new count is >= total. It sets flag 2+d if that flag is enabled, and it disarms the direction, so later increments raise no event.
- R7: An event whose enable bit holds 0 before the edge sets no flag, either then or when the enable is set later. A write to the enable word takes effect from the next cycle.
- R8: `start_i[d]` clears the counter of direction d and arms it, and any increment in that same cycle is dropped. A write of the total clears the counter and disarms the direction unless a start comes in the same cycle. Both actions rearm the midpoint detection.
- R9: When an event and a 0-write to the same flag fall in the same cycle, the flag ends at 1.
- R10: After reset, all flags, enables, totals and counters are 0 and all three interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (3) | Register address |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Read data for `reg_addr_i`, combinational |
| start_i | input | 4 | Per-direction transfer start pulse |
| inc_valid_i | input | 4 | Per-direction byte increment valid |
| inc_bytes_i | input | 4 x INC_W (8) | Per-direction bytes moved this cycle |
| usb_end_i | input | 1 | USB transfer done pulse |
| usb_addr_err_i | input | 1 | USB address error pulse |
| irq_err_o | output | 1 | Address error interrupt line |
| irq_end_o | output | 1 | Transfer end interrupt line |
| irq_half_o | output | 1 | Transfer midpoint interrupt line |

## Verification
Every event, flag clear, enable write and total write is sampled at one rising edge and shows in the registered state just after that edge. The interrupt lines and the read data follow that state with no further register in between, so each result is due one edge after its stimulus. The bench drives inputs one time unit after a rising edge. It then compares read data and all three lines against its own model one time unit after the next edge, every cycle, so the comparison never falls on an edge. Directed sequences place midpoint and end thresholds on exact counts, including odd totals and a restart in mid-transfer, and random traffic covers overlaps of events and clears.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int N_DIR     = 4;
  localparam int NUM_FLAGS = 2 + 2 * N_DIR;
  localparam int FB_ERR    = 0;
  localparam int FB_USB    = 1;
  localparam int FB_END0   = 2;
  localparam int FB_HALF0  = FB_END0 + N_DIR;
  localparam int A_EN      = 0;
  localparam int A_FLAG    = 1;
  localparam int A_TOT0    = 2;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/dma_dir_counter.sv
module dma_dir_counter #(
  parameter int CNT_W = 12,
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tot_we_i,
  input  logic [CNT_W-1:0] tot_wdata_i,
  input  logic             inc_valid_i,
  input  logic [INC_W-1:0] inc_bytes_i,
  output logic [CNT_W-1:0] total_o,
  output logic             half_ev_o,
  output logic             full_ev_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, tot_q;
  logic             act_q, half_q;
  logic             clr, adv;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] half_thr;

  assign clr      = start_i | tot_we_i;
  assign adv      = act_q & inc_valid_i & ~clr;
  assign sum      = {1'b0, cnt_q} + SUM_W'(inc_bytes_i);
  assign half_thr = tot_q >> 1;

  assign half_ev_o = adv & ~half_q & (sum >= {1'b0, half_thr});
  assign full_ev_o = adv & (sum >= {1'b0, tot_q});
  assign total_o   = tot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tot_q  <= '0;
      act_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (tot_we_i) tot_q <= tot_wdata_i;
      if (clr) begin
        cnt_q  <= '0;
        half_q <= 1'b0;
        act_q  <= start_i;
      end else if (adv) begin
        // wrap past total is harmless: end event disarms in the same cycle
        cnt_q <= sum[CNT_W-1:0];
        if (half_ev_o) half_q <= 1'b1;
        if (full_ev_o) act_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
  parameter int NF = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_we_i,
  input  logic [NF-1:0] en_wdata_i,
  input  logic          fl_we_i,
  input  logic [NF-1:0] fl_wdata_i,
  input  logic [NF-1:0] ev_i,
  output logic [NF-1:0] en_o,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] en_q, flag_q, flag_nxt;

  // clear first, then set: an event beats a same-cycle clear
  always_comb begin
    flag_nxt = fl_we_i ? (flag_q & fl_wdata_i) : flag_q;
    flag_nxt = flag_nxt | (ev_i & en_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= flag_nxt;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int CNT_W  = 12,
  parameter int INC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     reg_we_i,
  input  logic [ADDR_W-1:0]                        reg_addr_i,
  input  logic [DATA_W-1:0]                        reg_wdata_i,
  output logic [DATA_W-1:0]                        reg_rdata_o,
  input  logic [dma_irq_pkg::N_DIR-1:0]            start_i,
  input  logic [dma_irq_pkg::N_DIR-1:0]            inc_valid_i,
  input  logic [dma_irq_pkg::N_DIR-1:0][INC_W-1:0] inc_bytes_i,
  input  logic                                     usb_end_i,
  input  logic                                     usb_addr_err_i,
  output logic                                     irq_err_o,
  output logic                                     irq_end_o,
  output logic                                     irq_half_o
);
  import dma_irq_pkg::*;
  localparam int NF = NUM_FLAGS;

  flag_vec_t                  ev_w, en_w, flag_w;
  logic [N_DIR-1:0]           half_ev, full_ev;
  logic [N_DIR-1:0][CNT_W-1:0] total_w;
  logic                       en_we, fl_we;
  logic                       unused_wdata_hi;

  assign en_we           = reg_we_i && (reg_addr_i == ADDR_W'(A_EN));
  assign fl_we           = reg_we_i && (reg_addr_i == ADDR_W'(A_FLAG));
  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:CNT_W];

  assign ev_w[FB_ERR] = usb_addr_err_i;
  assign ev_w[FB_USB] = usb_end_i;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    logic tot_we;
    assign tot_we = reg_we_i && (reg_addr_i == ADDR_W'(A_TOT0 + d));

    dma_dir_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) cnt_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i[d]),
      .tot_we_i    (tot_we),
      .tot_wdata_i (reg_wdata_i[CNT_W-1:0]),
      .inc_valid_i (inc_valid_i[d]),
      .inc_bytes_i (inc_bytes_i[d]),
      .total_o     (total_w[d]),
      .half_ev_o   (half_ev[d]),
      .full_ev_o   (full_ev[d])
    );

    assign ev_w[FB_END0+d]  = full_ev[d];
    assign ev_w[FB_HALF0+d] = half_ev[d];
  end

  dma_flag_bank #(.NF(NF)) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_we_i    (en_we),
    .en_wdata_i (reg_wdata_i[NF-1:0]),
    .fl_we_i    (fl_we),
    .fl_wdata_i (reg_wdata_i[NF-1:0]),
    .ev_i       (ev_w),
    .en_o       (en_w),
    .flag_o     (flag_w)
  );

  assign irq_err_o  = flag_w[FB_ERR];
  assign irq_end_o  = |flag_w[FB_HALF0-1:FB_USB];
  assign irq_half_o = |flag_w[FB_HALF0+N_DIR-1:FB_HALF0];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_EN))   reg_rdata_o[NF-1:0] = en_w;
    if (reg_addr_i == ADDR_W'(A_FLAG)) reg_rdata_o[NF-1:0] = flag_w;
    for (int d = 0; d < N_DIR; d++) begin
      if (reg_addr_i == ADDR_W'(A_TOT0 + d)) reg_rdata_o[CNT_W-1:0] = total_w[d];
    end
  end
endmodule

// File: rtl/dma_irq_flags_chk.sv
module dma_irq_flags_chk #(
  parameter int NF     = 10,
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [NF-1:0]     wd_i,
  input logic [NF-1:0]     en_q,
  input logic [NF-1:0]     flag_q,
  input logic [NF-1:0]     ev
);
  logic fl_wr;
  assign fl_wr = reg_we_i && (reg_addr_i == ADDR_W'(dma_irq_pkg::A_FLAG));

  for (genvar b = 0; b < NF; b++) begin : g_bit
    assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev[b] && en_q[b]) |=> flag_q[b]);
    assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[b] && !(ev[b] && en_q[b])) |=> !flag_q[b]);
    assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl_wr && !wd_i[b] && !(ev[b] && en_q[b])) |=> !flag_q[b]);
    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[b] && !(fl_wr && !wd_i[b])) |=> flag_q[b]);
  end
endmodule

bind dma_irq_flags dma_irq_flags_chk #(.NF(NF), .ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wd_i       (reg_wdata_i[NF-1:0]),
  .en_q       (en_w),
  .flag_q     (flag_w),
  .ev         (ev_w)
);

// File: tb/dma_irq_flags_tb_top.sv
module dma_irq_flags_tb_top;
  localparam int CLK_PERIOD = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            we = 1'b0;
  logic [2:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [3:0]      start = '0, incv = '0;
  logic [3:0][7:0] incb = '0;
  logic            usb_end = 1'b0, addr_err = 1'b0;
  logic            irq_err, irq_end, irq_half;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R10";

  int       m_cnt[4], m_tot[4];
  bit       m_act[4], m_hd[4];
  logic [9:0] m_en = '0, m_fl = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_irq_flags dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .start_i(start),
    .inc_valid_i(incv), .inc_bytes_i(incb), .usb_end_i(usb_end),
    .usb_addr_err_i(addr_err), .irq_err_o(irq_err), .irq_end_o(irq_end),
    .irq_half_o(irq_half)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_step();
    logic [9:0] ev;
    logic [9:0] nf;
    ev = '0;
    ev[0] = addr_err;
    ev[1] = usb_end;
    for (int d = 0; d < 4; d++) begin
      bit tw;
      tw = we && (addr == 3'(2 + d));
      if (tw) m_tot[d] = int'(wdata[11:0]);
      if (tw || start[d]) begin
        m_cnt[d] = 0; m_hd[d] = 0; m_act[d] = start[d];
      end else if (m_act[d] && incv[d]) begin
        int s;
        s = m_cnt[d] + int'(incb[d]);
        if (!m_hd[d] && s >= m_tot[d] / 2) begin ev[6+d] = 1'b1; m_hd[d] = 1; end
        if (s >= m_tot[d]) begin ev[2+d] = 1'b1; m_act[d] = 0; end
        m_cnt[d] = s;
      end
    end
    nf = (we && addr == 3'd1) ? (m_fl & wdata[9:0]) : m_fl;
    nf = nf | (ev & m_en);
    if (we && addr == 3'd0) m_en = wdata[9:0];
    m_fl = nf;
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {22'd0, m_en};
      3'd1: return {22'd0, m_fl};
      3'd2, 3'd3, 3'd4, 3'd5: return 32'(m_tot[a-2]);
      default: return '0;
    endcase
  endfunction

  task automatic step();
    model_step();
    @(posedge clk_i);
    #1;
    chk({cur_tag, " R2 rdata"}, rdata, exp_rd(addr));
    chk("R1 irq_err", 32'(irq_err), 32'(m_fl[0]));
    chk("R1 irq_end", 32'(irq_end), 32'(|m_fl[5:1]));
    chk("R1 irq_half", 32'(irq_half), 32'(|m_fl[9:6]));
    we = 1'b0; start = '0; incv = '0; usb_end = 1'b0; addr_err = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
  endtask

  task automatic inc(int d, int n);
    addr = 3'd1; incv[d] = 1'b1; incb[d] = 8'(n);
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int d = 0; d < 4; d++) begin m_cnt[d] = 0; m_tot[d] = 0; m_act[d] = 0; m_hd[d] = 0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R10 reset state
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R10 reset read", rdata, 32'd0);
    end
    chk("R10 irq lines", {29'd0, irq_err, irq_end, irq_half}, 32'd0);

    wr(3'd0, 32'h3FF);
    cur_tag = "R3"; addr = 3'd1; addr_err = 1'b1; step();
    chk("R3 err flag", rdata, 32'h001);
    chk("R3 irq_err", 32'(irq_err), 32'd1);

    cur_tag = "R9"; addr = 3'd1; wdata = 32'h0; we = 1'b1; usb_end = 1'b1; step();
    chk("R9 event beats clear", rdata, 32'h002);
    chk("R1 err line drops, end line up", {30'd0, irq_err, irq_end}, 32'd1);

    cur_tag = "R4"; wr(3'd1, 32'h0); addr = 3'd1; usb_end = 1'b1; step();
    chk("R4 usb done flag", rdata, 32'h002);

    cur_tag = "R7";
    wr(3'd0, 32'h3FD); wr(3'd1, 32'h0);
    addr = 3'd1; usb_end = 1'b1; step();
    chk("R7 disabled event", rdata, 32'h0);
    wr(3'd0, 32'h3FF); addr = 3'd1; step();
    chk("R7 late enable", rdata, 32'h0);

    cur_tag = "R5";
    wr(3'd2, 32'd10); addr = 3'd1; start[0] = 1'b1; step();
    inc(0, 3); chk("R5 below half", rdata, 32'h0);
    inc(0, 2); chk("R5 half at 5 of 10", rdata, 32'h040);
    chk("R1 half line", 32'(irq_half), 32'd1);
    cur_tag = "R6";
    inc(0, 4); chk("R6 below total", rdata, 32'h040);
    inc(0, 1); chk("R6 end at 10", rdata, 32'h044);
    wr(3'd1, 32'h0); inc(0, 5);
    chk("R6 disarmed after end", rdata, 32'h0);

    cur_tag = "R8";
    wr(3'd3, 32'd8); addr = 3'd1; start[1] = 1'b1; step();
    inc(1, 3);
    addr = 3'd1; start[1] = 1'b1; incv[1] = 1'b1; incb[1] = 8'd9; step();
    chk("R8 start drops inc", rdata, 32'h0);
    inc(1, 3); chk("R8 restart count 3<4", rdata, 32'h0);
    inc(1, 1); chk("R8 half after restart", rdata, 32'h080);
    wr(3'd3, 32'd8); inc(1, 20);
    chk("R8 total write disarms", rdata, 32'h080);

    cur_tag = "R5";
    wr(3'd1, 32'h0); wr(3'd4, 32'd7); addr = 3'd1; start[2] = 1'b1; step();
    inc(2, 3); chk("R5 odd total half=3", rdata, 32'h100);
    inc(2, 4); chk("R6 odd total end, half once", rdata, 32'h110);

    cur_tag = "RND";
    for (int i = 0; i < 3000; i++) begin
      addr = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 3) == 0);
      wdata = $urandom;
      if (we && addr >= 3'd2 && addr <= 3'd5) wdata = 32'($urandom_range(0, 40));
      if (we && addr == 3'd0 && $urandom_range(0, 1) == 1) wdata = 32'h3FF;
      for (int d = 0; d < 4; d++) begin
        start[d] = ($urandom_range(0, 19) == 0);
        incv[d]  = ($urandom_range(0, 1) == 1);
        incb[d]  = 8'($urandom_range(0, 15));
      end
      usb_end  = ($urandom_range(0, 15) == 0);
      addr_err = ($urandom_range(0, 15) == 0);
      step();
    end
    finish_run();
  end
endmodule